// File: doc/BRIEF.md
# System Control Interrupt and Clock Divider

This block is the system-control register file of a small microcontroller. A simple word-addressed register port gives software read access to fixed identification and capability words, a handful of writable power and reset-cause registers, nine clock-gating words that are plain storage, and a seven-bit interrupt status register with a mask and a write-one-to-clear path. A single level interrupt output is high whenever a masked status bit is set.

Two run-mode clock configuration words set the system clock period. Each holds a divider field, and the second word has a wider divider and an override bit that lets it take precedence over the first. The block turns whichever divider is in force into a clock period value (a fixed step times divider plus one), which timers elsewhere use. When software takes the PLL out of power-down by clearing bit 13 of either clock word, the block raises a PLL-lock status bit. A read-only PLL configuration word is looked up from a per-class table using the crystal field of the first clock word.

The device class comes from identification word 0 and is fixed at elaboration. On the older class the second clock word does not exist: writes to it are dropped and it reads as zero.

Top module: `sysctl_clkirq`

## Requirements
- R1: After reset the raw status (0x050), mask (0x054) and interrupt output are zero, the first clock word (0x060) holds its reset parameter, and the second clock word (0x070) reads 0x07802810 on the newer class and zero on the older class.
- R2: The mask register keeps only bits [6:0] of a write; a read of 0x058 returns raw status AND mask, and the interrupt output is high exactly when that value is nonzero.
- R3: Writing 0x058 clears every raw status bit written as 1 and leaves the bits written as 0 unchanged.
- R4: A write to the first clock word sets raw status bit 6 only when the stored bit 13 is 1 and the written bit 13 is 0; the other three bit 13 transitions leave status unchanged.
- R5: The same bit 13 falling rule applies to writes of the second clock word on the newer class.
- R6: When bit 31 of the second clock word is 1 the clock period output is 5 x (bits [28:23] of that word + 1); otherwise it is 5 x (bits [26:23] of the first clock word + 1), and it follows every change of either word from the cycle after the write.
- R7: The class is older when bits [30:28] of identification word 0 are zero, or when they are nonzero and bits [23:16] are not 1; on the older class writes to 0x070 leave it reading zero, raise no status and do not change the clock period.
- R8: Writes keep bits [15:0] at 0x030, bits [4:0] at 0x034 and bits [5:0] at 0x05C, reading zero above them.
- R9: A read of 0x064 returns the entry of the class's 16-entry PLL table selected by bits [9:6] of the first clock word.
- R10: Identification words (0x000, 0x004) and capability words (0x008, 0x010 to 0x01C) return their parameters and ignore writes.
- R11: The nine clock-gating words at 0x100-0x108, 0x110-0x118 and 0x120-0x128 store and read back all 32 bits.
- R12: Offsets not listed read as zero and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Write strobe for one cycle |
| regAddr | input | 12 | Byte address of the register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr, combinational |
| irqOut | output | 1 | Level interrupt, masked status nonzero |
| clkPeriod | output | 9 | System clock period value |

## Verification
The bench aims at the bit 13 transition rule: a design that fired on any write with bit 13 low, or on the rising edge, would set status bit 6 on the 0-to-0 or 0-to-1 writes it issues, and one that watched only the first clock word would miss the falling edge on the second. It runs an older-class instance alongside the newer one, where an unguarded second word would read back written data, raise status or change the period. The override bit is driven to both divider extremes, so a design that used the narrow field or forgot the plus one would report 5 or 320 wrongly. A random mix of mask, clear and clock writes checks that clearing leaves unwritten bits alone and that the output tracks the masked value.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 12;
  localparam int IRQ_W   = 7;
  localparam int GATE_G  = 3;
  localparam int GATE_PER = 3;
  localparam int GATE_N  = GATE_G * GATE_PER;
  localparam int GATE_IW = $clog2(GATE_N);

  // Field positions that the clock logic decodes.
  localparam int PD_BIT   = 13;
  localparam int OVR_BIT  = 31;
  localparam int DIV_LO   = 23;
  localparam int DIV1_W   = 4;
  localparam int DIV2_W   = 6;
  localparam int XTAL_LO  = 6;
  localparam int PLL_IRQ  = 6;

  typedef enum logic [4:0] {
    RS_ZERO, RS_ID0, RS_ID1, RS_CAP0, RS_CAP1, RS_CAP2, RS_CAP3, RS_CAP4,
    RS_BOR, RS_LDO, RS_RAW, RS_MASK, RS_MASKED, RS_CAUSE,
    RS_RUN1, RS_PLL, RS_RUN2, RS_GATE
  } rdSel_e;

  typedef struct packed {
    logic              wrBor;
    logic              wrLdo;
    logic              wrMask;
    logic              wrClr;
    logic              wrCause;
    logic              wrRun1;
    logic              wrRun2;
    logic [GATE_N-1:0] wrGate;
  } strobe_t;

  typedef enum logic {CLS_OLD, CLS_NEW} devClass_e;

  function automatic devClass_e classOf(logic [DATA_W-1:0] id0);
    if (id0[30:28] == 3'd0) return CLS_OLD;
    return (id0[23:16] == 8'd1) ? CLS_NEW : CLS_OLD;
  endfunction

  function automatic logic [15:0][15:0] mkPllTable(logic [15:0] base, logic [15:0] step);
    logic [15:0][15:0] t;
    for (int i = 0; i < 16; i++) t[i] = base + step * 16'(i);
    return t;
  endfunction
endpackage

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  output strobe_t           strb,
  output rdSel_e            rdSel,
  output logic [GATE_IW-1:0] gateIdx
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] GATE_BASE = WORD_W'(12'h100 >> 2);

  logic [WORD_W-1:0] word;
  logic [GATE_N-1:0] gateHit;

  assign word = regAddr[ADDR_W-1:2];

  // Gating words: groups 16 bytes apart, three words per group.
  for (genvar g = 0; g < GATE_G; g++) begin : g_grp
    for (genvar i = 0; i < GATE_PER; i++) begin : g_word
      assign gateHit[g*GATE_PER+i] = (word == GATE_BASE + WORD_W'(g*4 + i));
    end
  end

  always_comb begin
    strb    = '0;
    rdSel   = RS_ZERO;
    gateIdx = '0;
    case (word)
      WORD_W'(10'h000): rdSel = RS_ID0;
      WORD_W'(10'h001): rdSel = RS_ID1;
      WORD_W'(10'h002): rdSel = RS_CAP0;
      WORD_W'(10'h004): rdSel = RS_CAP1;
      WORD_W'(10'h005): rdSel = RS_CAP2;
      WORD_W'(10'h006): rdSel = RS_CAP3;
      WORD_W'(10'h007): rdSel = RS_CAP4;
      WORD_W'(10'h00C): begin rdSel = RS_BOR;    strb.wrBor   = regWr; end
      WORD_W'(10'h00D): begin rdSel = RS_LDO;    strb.wrLdo   = regWr; end
      WORD_W'(10'h014): rdSel = RS_RAW;
      WORD_W'(10'h015): begin rdSel = RS_MASK;   strb.wrMask  = regWr; end
      WORD_W'(10'h016): begin rdSel = RS_MASKED; strb.wrClr   = regWr; end
      WORD_W'(10'h017): begin rdSel = RS_CAUSE;  strb.wrCause = regWr; end
      WORD_W'(10'h018): begin rdSel = RS_RUN1;   strb.wrRun1  = regWr; end
      WORD_W'(10'h019): rdSel = RS_PLL;
      WORD_W'(10'h01C): begin rdSel = RS_RUN2;   strb.wrRun2  = regWr; end
      default: begin
        if (|gateHit) begin
          rdSel       = RS_GATE;
          strb.wrGate = regWr ? gateHit : '0;
        end
      end
    endcase
    for (int j = 0; j < GATE_N; j++)
      if (gateHit[j]) gateIdx = GATE_IW'(j);
  end

  // R12: no write strobe leaves the decoder without a write request.
  p_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    !regWr |-> (strb == '0));
  // R12: one address never drives two register writes.
  p_single_r12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));
endmodule

// File: rtl/sysctl_dp.sv
module sysctl_dp
  import sysctl_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID0        = 32'h1001_0000,
  parameter logic [DATA_W-1:0] ID1        = 32'h0000_0000,
  parameter logic [DATA_W-1:0] CAP0       = 32'h0000_0000,
  parameter logic [DATA_W-1:0] CAP1       = 32'h0000_0000,
  parameter logic [DATA_W-1:0] CAP2       = 32'h0000_0000,
  parameter logic [DATA_W-1:0] CAP3       = 32'h0000_0000,
  parameter logic [DATA_W-1:0] CAP4       = 32'h0000_0000,
  parameter logic [DATA_W-1:0] CAUSE_INIT = 32'h0000_0000,
  parameter logic [DATA_W-1:0] RUN1_INIT  = 32'h0000_0000,
  parameter logic [DATA_W-1:0] RUN2_INIT  = 32'h0000_0000,
  parameter logic [15:0][15:0] PLL_TBL    = '0,
  parameter bit                IS_NEW     = 1'b1,
  parameter int                CLK_STEP   = 5,
  parameter int                PERIOD_W   = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  rdSel_e              rdSel,
  input  logic [GATE_IW-1:0]  gateIdx,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  output logic                irqOut,
  output logic [PERIOD_W-1:0] clkPeriod
);
  logic [15:0]       borReg;
  logic [4:0]        ldoReg;
  logic [5:0]        causeReg;
  logic [IRQ_W-1:0]  rawReg, maskReg, rawNext, maskedVal;
  logic [DATA_W-1:0] run1Reg, run2Reg;
  logic [DATA_W-1:0] gateReg [GATE_N];
  logic              pllEvent;
  logic [DIV2_W-1:0] divSel;

  assign pllEvent = (strb.wrRun1 && run1Reg[PD_BIT] && !wdata[PD_BIT]) ||
                    (IS_NEW && strb.wrRun2 && run2Reg[PD_BIT] && !wdata[PD_BIT]);

  always_comb begin
    rawNext = rawReg;
    if (strb.wrClr) rawNext = rawNext & ~wdata[IRQ_W-1:0];
    if (pllEvent)   rawNext[PLL_IRQ] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      borReg   <= '0;
      ldoReg   <= '0;
      causeReg <= CAUSE_INIT[5:0];
      rawReg   <= '0;
      maskReg  <= '0;
      run1Reg  <= RUN1_INIT;
      run2Reg  <= IS_NEW ? RUN2_INIT : '0;
    end else begin
      rawReg <= rawNext;
      if (strb.wrBor)   borReg   <= wdata[15:0];
      if (strb.wrLdo)   ldoReg   <= wdata[4:0];
      if (strb.wrCause) causeReg <= wdata[5:0];
      if (strb.wrMask)  maskReg  <= wdata[IRQ_W-1:0];
      if (strb.wrRun1)  run1Reg  <= wdata;
      if (IS_NEW && strb.wrRun2) run2Reg <= wdata;
    end
  end

  for (genvar j = 0; j < GATE_N; j++) begin : g_gate
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               gateReg[j] <= '0;
      else if (strb.wrGate[j]) gateReg[j] <= wdata;
    end
  end

  assign maskedVal = rawReg & maskReg;
  assign irqOut    = |maskedVal;

  always_comb begin
    if (run2Reg[OVR_BIT]) divSel = run2Reg[DIV_LO +: DIV2_W];
    else                  divSel = DIV2_W'(run1Reg[DIV_LO +: DIV1_W]);
    clkPeriod = PERIOD_W'(CLK_STEP * (int'(divSel) + 1));
  end

  always_comb begin
    case (rdSel)
      RS_ID0:    rdata = ID0;
      RS_ID1:    rdata = ID1;
      RS_CAP0:   rdata = CAP0;
      RS_CAP1:   rdata = CAP1;
      RS_CAP2:   rdata = CAP2;
      RS_CAP3:   rdata = CAP3;
      RS_CAP4:   rdata = CAP4;
      RS_BOR:    rdata = DATA_W'(borReg);
      RS_LDO:    rdata = DATA_W'(ldoReg);
      RS_RAW:    rdata = DATA_W'(rawReg);
      RS_MASK:   rdata = DATA_W'(maskReg);
      RS_MASKED: rdata = DATA_W'(maskedVal);
      RS_CAUSE:  rdata = DATA_W'(causeReg);
      RS_RUN1:   rdata = run1Reg;
      RS_PLL:    rdata = DATA_W'(PLL_TBL[run1Reg[XTAL_LO +: 4]]);
      RS_RUN2:   rdata = run2Reg;
      RS_GATE:   rdata = gateReg[gateIdx];
      default:   rdata = '0;
    endcase
  end

  // R3: bits written as one are clear in the following cycle.
  p_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrClr |=> ((rawReg & $past(wdata[IRQ_W-1:0])) == '0));
  // R4: falling power-down bit of the first clock word raises bit 6.
  p_pll_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrRun1 && run1Reg[PD_BIT] && !wdata[PD_BIT]) |=> rawReg[PLL_IRQ]);
  // R5: status bit 6 only appears after a clock word write.
  p_pll_src_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rawReg[PLL_IRQ]) |-> $past(strb.wrRun1 || strb.wrRun2));
  // R7: on the older class a second-word write changes nothing.
  p_old_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!IS_NEW && strb.wrRun2) |=> ($stable(run2Reg) && $stable(clkPeriod)));
  // R6: the period is a whole number of steps within the divider range.
  p_period_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    (clkPeriod >= PERIOD_W'(CLK_STEP)) &&
    (clkPeriod <= PERIOD_W'(CLK_STEP * (2**DIV2_W))));
endmodule

// File: rtl/sysctl_clkirq.sv
module sysctl_clkirq
  import sysctl_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID0        = 32'h1001_0000,
  parameter logic [DATA_W-1:0] ID1        = 32'h0000_0000,
  parameter logic [DATA_W-1:0] CAP0       = 32'h0000_0000,
  parameter logic [DATA_W-1:0] CAP1       = 32'h0000_0000,
  parameter logic [DATA_W-1:0] CAP2       = 32'h0000_0000,
  parameter logic [DATA_W-1:0] CAP3       = 32'h0000_0000,
  parameter logic [DATA_W-1:0] CAP4       = 32'h0000_0000,
  parameter logic [DATA_W-1:0] CAUSE_INIT = 32'h0000_0000,
  parameter logic [DATA_W-1:0] RUN1_INIT  = 32'h078E_3AC0,
  parameter logic [DATA_W-1:0] RUN2_INIT  = 32'h0780_2810,
  parameter logic [15:0][15:0] PLL_NEW    = mkPllTable(16'h1B20, 16'h0913),
  parameter logic [15:0][15:0] PLL_OLD    = mkPllTable(16'h1AE0, 16'h0877),
  parameter int                CLK_STEP   = 5,
  localparam int               PERIOD_W   = $clog2(CLK_STEP * (2**DIV2_W) + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWr,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWdata,
  output logic [DATA_W-1:0]   regRdata,
  output logic                irqOut,
  output logic [PERIOD_W-1:0] clkPeriod
);
  localparam bit IS_NEW = (classOf(ID0) == CLS_NEW);

  strobe_t            strb;
  rdSel_e             rdSel;
  logic [GATE_IW-1:0] gateIdx;

  sysctl_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .strb(strb), .rdSel(rdSel), .gateIdx(gateIdx)
  );

  sysctl_dp #(
    .ID0(ID0), .ID1(ID1), .CAP0(CAP0), .CAP1(CAP1), .CAP2(CAP2),
    .CAP3(CAP3), .CAP4(CAP4), .CAUSE_INIT(CAUSE_INIT),
    .RUN1_INIT(RUN1_INIT), .RUN2_INIT(RUN2_INIT),
    .PLL_TBL(IS_NEW ? PLL_NEW : PLL_OLD), .IS_NEW(IS_NEW),
    .CLK_STEP(CLK_STEP), .PERIOD_W(PERIOD_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdSel(rdSel), .gateIdx(gateIdx),
    .wdata(regWdata), .rdata(regRdata), .irqOut(irqOut), .clkPeriod(clkPeriod)
  );
endmodule

// File: tb/sysctl_clkirq_bench.sv
module sysctl_clkirq_bench;
  localparam logic [31:0] ID0_NEW = 32'h1001_00A5;
  localparam logic [31:0] ID0_OLD = 32'h0003_0000;  // version 0 wins over class 3
  localparam logic [31:0] CAP2_V  = 32'h0107_1013;
  localparam logic [31:0] RUN1_V  = 32'h078E_3AC0;

  function automatic logic [15:0][15:0] tbl(logic [15:0] base);
    logic [15:0][15:0] t;
    for (int i = 0; i < 16; i++) t[i] = base ^ (16'(i) * 16'h0351);
    return t;
  endfunction
  localparam logic [15:0][15:0] TB_NEW = tbl(16'h4A00);
  localparam logic [15:0][15:0] TB_OLD = tbl(16'h2500);

  logic clk = 1'b0, rstN = 1'b0, regWr = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] rdata0, rdata1;
  logic irq0, irq1;
  logic [8:0] per0, per1;

  always #4 clk = ~clk;

  sysctl_clkirq #(.ID0(ID0_NEW), .CAP2(CAP2_V), .RUN1_INIT(RUN1_V),
                  .PLL_NEW(TB_NEW), .PLL_OLD(TB_OLD)) u_sysctl_clkirq (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(rdata0), .irqOut(irq0), .clkPeriod(per0));

  sysctl_clkirq #(.ID0(ID0_OLD), .CAP2(CAP2_V), .RUN1_INIT(RUN1_V),
                  .PLL_NEW(TB_NEW), .PLL_OLD(TB_OLD)) u_sysctl_clkirq_old (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(rdata1), .irqOut(irq1), .clkPeriod(per1));

  int compared = 0, mismatched = 0;
  logic [6:0]  mRaw [2];
  logic [6:0]  mMask [2];
  logic [31:0] mRun1 [2];
  logic [31:0] mRun2 [2];

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] expPeriod(int k);
    int d;
    d = mRun2[k][31] ? int'(mRun2[k][28:23]) : int'(mRun1[k][26:23]);
    return 32'(5 * (d + 1));
  endfunction

  task automatic rd(logic [11:0] a);
    regAddr = a;
    #1;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
    for (int k = 0; k < 2; k++) begin
      case (a)
        12'h054: mMask[k] = d[6:0];
        12'h058: mRaw[k]  = mRaw[k] & ~d[6:0];
        12'h060: begin
          if (mRun1[k][13] && !d[13]) mRaw[k][6] = 1'b1;
          mRun1[k] = d;
        end
        12'h070: if (k == 0) begin
          if (mRun2[k][13] && !d[13]) mRaw[k][6] = 1'b1;
          mRun2[k] = d;
        end
        default: ;
      endcase
    end
  endtask

  task automatic checkState(string tag);
    rd(12'h050);
    chk({tag, " raw new"}, rdata0, {25'd0, mRaw[0]});
    chk({tag, " raw old"}, rdata1, {25'd0, mRaw[1]});
    rd(12'h058);
    chk({tag, " masked new"}, rdata0, {25'd0, mRaw[0] & mMask[0]});
    chk({tag, " masked old"}, rdata1, {25'd0, mRaw[1] & mMask[1]});
    chk({tag, " irq new"}, {31'd0, irq0}, {31'd0, |(mRaw[0] & mMask[0])});
    chk({tag, " irq old"}, {31'd0, irq1}, {31'd0, |(mRaw[1] & mMask[1])});
    chk({tag, " period new"}, {23'd0, per0}, expPeriod(0));
    chk({tag, " period old"}, {23'd0, per1}, expPeriod(1));
  endtask

  initial begin
    #1600000;
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    for (int k = 0; k < 2; k++) begin
      mRaw[k] = '0; mMask[k] = '0; mRun1[k] = RUN1_V;
    end
    mRun2[0] = 32'h0780_2810; mRun2[1] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset values
    checkState("R1 reset");
    rd(12'h060); chk("R1 run1 reset", rdata0, RUN1_V);
    rd(12'h070); chk("R1 run2 reset new", rdata0, 32'h0780_2810);
    chk("R7 run2 reset old", rdata1, 32'h0);

    // R10: identification and capability are read-only
    rd(12'h000); chk("R10 id0", rdata0, ID0_NEW);
    rd(12'h014); chk("R10 cap2", rdata0, CAP2_V);
    wr(12'h000, 32'hFFFF_FFFF); wr(12'h014, 32'h0);
    rd(12'h000); chk("R10 id0 after write", rdata0, ID0_NEW);
    rd(12'h014); chk("R10 cap2 after write", rdata0, CAP2_V);

    // R8: write masks
    wr(12'h030, 32'hFFFF_FFFF); rd(12'h030); chk("R8 brown-out", rdata0, 32'h0000_FFFF);
    wr(12'h034, 32'hFFFF_FFFF); rd(12'h034); chk("R8 ldo", rdata0, 32'h0000_001F);
    wr(12'h05C, 32'hFFFF_FFFF); rd(12'h05C); chk("R8 cause", rdata0, 32'h0000_003F);

    // R11: gating storage
    wr(12'h100, 32'hDEAD_BEEF); wr(12'h128, 32'h1234_5678); wr(12'h114, 32'hA5A5_0F0F);
    rd(12'h100); chk("R11 gate first", rdata0, 32'hDEAD_BEEF);
    rd(12'h128); chk("R11 gate last", rdata0, 32'h1234_5678);
    rd(12'h114); chk("R11 gate mid", rdata0, 32'hA5A5_0F0F);

    // R12: undefined offsets
    wr(12'h054, 32'h0000_0055);
    wr(12'h00C, 32'hFFFF_FFFF); wr(12'h10C, 32'hFFFF_FFFF); wr(12'h068, 32'hFFFF_FFFF);
    rd(12'h00C); chk("R12 hole 0x00C", rdata0, 32'h0);
    rd(12'h10C); chk("R12 hole 0x10C", rdata0, 32'h0);
    rd(12'h068); chk("R12 hole 0x068", rdata0, 32'h0);
    rd(12'h054); chk("R12 mask untouched", rdata0, 32'h55);
    // R2: mask keeps seven bits
    wr(12'h054, 32'hFFFF_FFC3); rd(12'h054); chk("R2 mask width", rdata0, 32'h43);

    // R4: bit 13 transitions on the first clock word (reset has it at 1)
    wr(12'h060, 32'h0000_2000); checkState("R4 1->1 no event");
    wr(12'h060, 32'h0000_0000); checkState("R4 1->0 event");
    wr(12'h058, 32'h0000_0040); checkState("R3 clear bit 6");
    wr(12'h060, 32'h0000_0000); checkState("R4 0->0 no event");
    wr(12'h060, 32'h0000_2000); checkState("R4 0->1 no event");

    // R5 / R7: second clock word
    wr(12'h070, 32'h0000_0000); checkState("R5 run2 1->0 event");
    rd(12'h070); chk("R7 old run2 ignores write", rdata1, 32'h0);
    wr(12'h058, 32'h7F); wr(12'h070, 32'h0000_2000); wr(12'h070, 32'h0000_0000);
    checkState("R5 run2 0->1->0 event, R7 none old");

    // R6: override and divider extremes
    wr(12'h060, 32'h0280_0000); checkState("R6 run1 divider 5");
    wr(12'h070, 32'h9F80_0000); checkState("R6 override max 320");
    rd(12'h070); chk("R7 old run2 still zero", rdata1, 32'h0);
    wr(12'h070, 32'h8000_0000); checkState("R6 override min 5");
    wr(12'h070, 32'h1F80_0000); checkState("R6 no override uses run1");

    // R9: PLL table lookup per class
    for (int x = 0; x < 16; x += 5) begin
      wr(12'h060, 32'(x) << 6);
      rd(12'h064);
      chk("R9 pll new", rdata0, {16'd0, TB_NEW[x]});
      chk("R9 pll old", rdata1, {16'd0, TB_OLD[x]});
    end

    // R2/R3/R4/R5/R6: random mix
    rv = $urandom(32'd20240611);
    for (int n = 0; n < 400; n++) begin
      int sel;
      sel = int'($urandom_range(0, 3));
      rv  = $urandom;
      case (sel)
        0: wr(12'h054, rv);
        1: wr(12'h058, rv);
        2: wr(12'h060, rv);
        default: wr(12'h070, rv);
      endcase
      checkState("R2/R3/R4/R5/R6 random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule